// File: doc/BRIEF.md
# Wireless Subsystem Power-Mode Controller

This block decides when the switchable part of a wireless subsystem is powered. It also gates three on-chip SRAM banks according to the current system power mode. The wireless side has two states: active and asleep. Software moves it between them with an enable bit and a sleep-request bit. The radio logic can move it with single-cycle sleep and wake strobes, but those strobes only count while the software enable bit is set. Clearing the enable bit always returns the subsystem to active.

Each SRAM bank has its own wake bit. The bit is honoured in the three working system modes. In the two lowest modes every bank is forced off, whatever its wake bit says. All decisions are taken at a clock edge, so every power-enable output changes one cycle after the input that caused it. A status flag shows whether the wireless sleep state is currently in effect.

Top module: `wlpwr_top`

## Requirements
- R1: After reset the subsystem is active. `wlSleeping`=0, `offDomainPwrEn`=1, `onDomainPwrEn`=1, and every bit of `sramPwrEn` is 0.
- R2: When `swEnable`=1, `hwWakeStrobe`=0 and `hwSleepStrobe`=1 are sampled at a clock edge, the subsystem is asleep after that edge (`wlSleeping`=1). With `swEnable`=0 the sleep strobe has no effect.
- R3: When `swEnable`=0 is sampled at an edge, the subsystem is active after that edge, whatever the other control inputs are.
- R4: When `swEnable`=1 and `hwWakeStrobe`=1 are sampled at an edge, the subsystem is active after that edge.
- R5: With `swEnable`=1 and both strobes low, a rising edge of `swSleepReq` (1 now, 0 at the previous edge) flips the state: active becomes asleep and asleep becomes active. Holding `swSleepReq` high does not flip it again.
- R6: Priority, highest first: enable cleared, hardware wake, hardware sleep, software toggle. Wake and sleep strobes together leave the subsystem active.
- R7: `offDomainPwrEn` is the inverse of `wlSleeping` at all times. `onDomainPwrEn` stays 1 after reset. Both follow the state one cycle after the triggering input.
- R8: With `sysMode` equal to run (0), sleep (1) or deep sleep (2), bit i of `sramPwrEn` equals bit i of `sramWake` as sampled at the previous clock edge.
- R9: With `sysMode` equal to standby (3), backup-only (4) or a reserved code (5 to 7), every bit of `sramPwrEn` is 0 one cycle later, whatever `sramWake` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swEnable | input | 1 | Software enable for wireless power management |
| swSleepReq | input | 1 | Software sleep request; a rising edge toggles the state |
| hwSleepStrobe | input | 1 | Sleep strobe from the radio logic |
| hwWakeStrobe | input | 1 | Wake strobe from the radio logic |
| sramWake | input | NUM_BANKS | Wake bit for each SRAM bank |
| sysMode | input | 3 | System mode: 0 run, 1 sleep, 2 deep sleep, 3 standby, 4 backup-only |
| offDomainPwrEn | output | 1 | Power enable for the switchable wireless domain |
| onDomainPwrEn | output | 1 | Power enable for the always-on wireless domain |
| sramPwrEn | output | NUM_BANKS | Power enable for each SRAM bank |
| wlSleeping | output | 1 | Status: 1 while the wireless sleep state is in effect |

## Verification
A wrong sleep state shows up on `wlSleeping` and `offDomainPwrEn` at the first negative clock edge after the edge that took it. The bench compares both outputs against its own state model on every cycle of a long mixed sequence of control inputs, so a bad transition is reported within one cycle. A lost or repeated edge detection on the sleep request makes the state flip at the wrong time, which the model catches on the next step. Gating faults in the SRAM path appear in the single cycle after a mode or wake-bit change. Every mode code is combined with every wake pattern.

// File: rtl/wlpwr_pkg.sv
`timescale 1ns/1ps
package wlpwr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 3'd0,
    MODE_SLEEP   = 3'd1,
    MODE_DEEP    = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_BACKUP  = 3'd4
  } sysMode_e;

  // Control-to-datapath strobes for one clock edge
  typedef struct packed {
    logic enterSleep;
    logic exitSleep;
  } wlStrobe_t;

  // Bank wake bits are honoured only in the working modes
  function automatic logic sramModeAllowed(input logic [MODE_W-1:0] mode);
    return (mode == MODE_RUN) || (mode == MODE_SLEEP) || (mode == MODE_DEEP);
  endfunction
endpackage

// File: rtl/wlpwr_ctrl.sv
`timescale 1ns/1ps
module wlpwr_ctrl
  import wlpwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      swEnable,
  input  logic      swSleepReq,
  input  logic      hwSleepStrobe,
  input  logic      hwWakeStrobe,
  input  logic      wlSleeping,
  output wlStrobe_t strobe
);
  logic reqQ;
  logic reqRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= swSleepReq;
  end

  assign reqRise = swSleepReq && !reqQ;

  // Priority: enable cleared, hw wake, hw sleep, sw toggle
  always_comb begin
    strobe = '0;
    if (!swEnable) begin
      strobe.exitSleep = 1'b1;
    end else if (hwWakeStrobe) begin
      strobe.exitSleep = 1'b1;
    end else if (hwSleepStrobe) begin
      strobe.enterSleep = 1'b1;
    end else if (reqRise) begin
      if (wlSleeping) strobe.exitSleep  = 1'b1;
      else            strobe.enterSleep = 1'b1;
    end
  end

  AST_DISABLE_FORCES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |=> !wlSleeping); // R3

  AST_HW_SLEEP_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && hwSleepStrobe && !hwWakeStrobe) |=> wlSleeping); // R2

  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && hwWakeStrobe) |=> !wlSleeping); // R6

  AST_SW_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && !hwWakeStrobe && !hwSleepStrobe && swSleepReq && !reqQ)
      |=> (wlSleeping != $past(wlSleeping))); // R5
endmodule

// File: rtl/wlpwr_datapath.sv
`timescale 1ns/1ps
module wlpwr_datapath
  import wlpwr_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wlStrobe_t            strobe,
  input  logic [NUM_BANKS-1:0] sramWake,
  input  logic [MODE_W-1:0]    sysMode,
  output logic                 wlSleeping,
  output logic                 offDomainPwrEn,
  output logic                 onDomainPwrEn,
  output logic [NUM_BANKS-1:0] sramPwrEn
);
  logic asleepQ;
  logic offEnQ;
  logic onEnQ;
  logic modeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asleepQ <= 1'b0;
      offEnQ  <= 1'b1;
      onEnQ   <= 1'b1;
    end else begin
      onEnQ <= 1'b1;
      if (strobe.exitSleep) begin
        asleepQ <= 1'b0;
        offEnQ  <= 1'b1;
      end else if (strobe.enterSleep) begin
        asleepQ <= 1'b1;
        offEnQ  <= 1'b0;
      end
    end
  end

  assign modeOk = sramModeAllowed(sysMode);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankEnQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankEnQ <= 1'b0;
      else       bankEnQ <= modeOk && sramWake[b];
    end
    assign sramPwrEn[b] = bankEnQ;
  end

  assign wlSleeping     = asleepQ;
  assign offDomainPwrEn = offEnQ;
  assign onDomainPwrEn  = onEnQ;

  AST_SRAM_LOW_MODE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (sysMode > 3'd2) |=> (sramPwrEn == '0)); // R9

  AST_SRAM_FOLLOWS_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (sysMode <= 3'd2) |=> (sramPwrEn == $past(sramWake))); // R8

  AST_OFF_DOMAIN_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    offDomainPwrEn != wlSleeping); // R7
endmodule

// File: rtl/wlpwr_top.sv
`timescale 1ns/1ps
module wlpwr_top
  import wlpwr_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swEnable,
  input  logic                 swSleepReq,
  input  logic                 hwSleepStrobe,
  input  logic                 hwWakeStrobe,
  input  logic [NUM_BANKS-1:0] sramWake,
  input  logic [2:0]           sysMode,
  output logic                 offDomainPwrEn,
  output logic                 onDomainPwrEn,
  output logic [NUM_BANKS-1:0] sramPwrEn,
  output logic                 wlSleeping
);
  wlStrobe_t strobe;

  wlpwr_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .swEnable      (swEnable),
    .swSleepReq    (swSleepReq),
    .hwSleepStrobe (hwSleepStrobe),
    .hwWakeStrobe  (hwWakeStrobe),
    .wlSleeping    (wlSleeping),
    .strobe        (strobe)
  );

  wlpwr_datapath #(.NUM_BANKS(NUM_BANKS)) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .sramWake       (sramWake),
    .sysMode        (sysMode),
    .wlSleeping     (wlSleeping),
    .offDomainPwrEn (offDomainPwrEn),
    .onDomainPwrEn  (onDomainPwrEn),
    .sramPwrEn      (sramPwrEn)
  );
endmodule

// File: tb/wlpwr_top_tb_top.sv
`timescale 1ns/1ps
module wlpwr_top_tb_top;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          swEnable = 1'b0;
  logic          swSleepReq = 1'b0;
  logic          hwSleepStrobe = 1'b0;
  logic          hwWakeStrobe = 1'b0;
  logic [NB-1:0] sramWake = '0;
  logic [2:0]    sysMode = 3'd0;
  logic          offDomainPwrEn;
  logic          onDomainPwrEn;
  logic [NB-1:0] sramPwrEn;
  logic          wlSleeping;

  int checks = 0;
  int failures = 0;
  logic expSleep = 1'b0;
  logic prevReq = 1'b0;

  always #2.5 clk = ~clk;

  wlpwr_top #(.NUM_BANKS(NB)) dut_i (
    .clk            (clk),
    .rstN           (rstN),
    .swEnable       (swEnable),
    .swSleepReq     (swSleepReq),
    .hwSleepStrobe  (hwSleepStrobe),
    .hwWakeStrobe   (hwWakeStrobe),
    .sramWake       (sramWake),
    .sysMode        (sysMode),
    .offDomainPwrEn (offDomainPwrEn),
    .onDomainPwrEn  (onDomainPwrEn),
    .sramPwrEn      (sramPwrEn),
    .wlSleeping     (wlSleeping)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at a negative edge, let one posedge pass, check at the next negedge
  task automatic step(input logic en, input logic req, input logic hs, input logic hw);
    string tag;
    logic rise;
    swEnable = en; swSleepReq = req; hwSleepStrobe = hs; hwWakeStrobe = hw;
    rise = req && !prevReq;
    prevReq = req;
    if (!en)      begin expSleep = 1'b0; tag = "R3"; end
    else if (hw)  begin expSleep = 1'b0; tag = hs ? "R6" : "R4"; end
    else if (hs)  begin expSleep = 1'b1; tag = "R2"; end
    else if (rise) begin expSleep = !expSleep; tag = "R5"; end
    else          tag = "R7";
    @(negedge clk);
    check(tag, int'(wlSleeping), int'(expSleep));
    check("R7 off-domain", int'(offDomainPwrEn), int'(!expSleep));
    check("R7 on-domain", int'(onDomainPwrEn), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sleeping", int'(wlSleeping), 0);
    check("R1 off-domain", int'(offDomainPwrEn), 1);
    check("R1 on-domain", int'(onDomainPwrEn), 1);
    check("R1 sram", int'(sramPwrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 sram after release", int'(sramPwrEn), 0);

    // R2: hw sleep ignored while disabled, accepted when enabled
    step(0, 0, 1, 0);
    step(1, 0, 1, 0);
    step(1, 0, 0, 0);
    // R4: hw wake exits
    step(1, 0, 0, 1);
    // R6: both strobes together leave it active
    step(1, 0, 1, 0);
    step(1, 0, 1, 1);
    // R5: toggle on rising edge only
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    // R5: rising edge ignored while disabled
    step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    // R3: clearing enable exits sleep
    step(1, 0, 1, 0);
    step(0, 0, 1, 0);

    // Mixed sequence against the state model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(|lfsr[2:0], lfsr[3], lfsr[4] & lfsr[5], lfsr[6] & lfsr[7] & lfsr[8]);
    end

    // SRAM gating: every mode against every wake pattern
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < (1 << NB); w++) begin
        sysMode = 3'(m);
        sramWake = NB'(w);
        @(negedge clk);
        if (m <= 2) check("R8 sram follows wake", int'(sramPwrEn), w);
        else        check("R9 sram forced off", int'(sramPwrEn), 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule